// File: doc/BRIEF.md
# LCD Multiplex Timing Generator

This block produces the digital timing for a multiplexed LCD panel. A single clock runs the whole block. A strobe input, `base_en`, marks each period of the slow drive clock. A power-of-two prescaler turns these strobes into a slot period. The slot period is split into two halves of opposite drive polarity, so every pin averages to zero DC within each slot. A slot counter steps through the active common time slots. For every common pin and every segment pin, the block outputs a 2-bit drive-level index, V0 to V3, which selects one rail of an external bias network.

One 16-bit control register holds the configuration: display on, common enable, two power-control bits, a drive mode and a frame-rate divider. The power-control bits are stored and read back only. The drive mode selects 4-, 3- or 2-way multiplex, or static drive, and each of these has its own bias scheme. The block presents the current slot index on a display-memory read port. In the same cycle it receives one bit per segment for that slot.

A new mode or rate written to the register is not used at once. It is adopted at the next frame boundary, so a frame in progress always completes with the settings it started with.

Top module: `lcd_mux_timing`

## Requirements
- R1: After reset the register reads 0x0000. Only bits 15 (display on), 14 (common enable), 13 (analog stop), 12 (supply enable), 6:4 (mode) and 1:0 (rate) are stored. Every other bit reads 0, and writes to those bits are ignored.
- R2: A full write loads all stored bits from `reg_wdata`. A bit write changes only bit `reg_bit_idx`, setting it to `reg_bit_val`. When both writes are asserted in the same cycle, the full write wins.
- R3: One slot lasts 2^(6+rate) `base_en` strobes. Cycles without a strobe do not advance the timing. Polarity is 0 for the first half of each slot and 1 for the second half.
- R4: The mode sets the number of slots per frame: 000 gives 4, 001 gives 3, 010 gives 2, 011 gives 3, and 1xx gives static drive with 1 slot. The slot index counts 0 up to N-1, then wraps to 0.
- R5: Modes 000 and 001 use 1/3 bias. The selected common is at V3 in polarity 0 and V0 in polarity 1. Every other common, including commons with index N or above, is at V1 in polarity 0 and V2 in polarity 1.
- R6: Modes 010 and 011 use 1/2 bias. The selected common is at V3 in polarity 0 and V0 in polarity 1. Every other common stays at V1.
- R7: In multiplex modes, a segment whose bit is on is at V0 in polarity 0 and V3 in polarity 1. A segment that is off is at V2/V1 (polarity 0/1) under 1/3 bias, and at V3/V0 under 1/2 bias.
- R8: In static drive, common 0 is at V0 in polarity 0 and V3 in polarity 1, and commons 1 to 3 stay at V0. A segment that is off follows common 0. A segment that is on takes the opposite level.
- R9: When display-on is 0, every segment carries the off waveform, whatever the display memory holds.
- R10: When common-enable is 0, every common and segment output is V0. The prescaler and the slot index are held at 0, and they restart from 0 when common-enable is set again.
- R11: A new mode or rate written while the display runs takes effect at the next frame boundary. The new frame starts at slot 0.
- R12: `dm_slot` shows the current slot index. Segment outputs follow `dm_bits` in the same cycle.
- R13: The analog-stop and supply-enable bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One strobe per period of the slow drive clock |
| reg_wr_full | input | 1 | Full-width register write |
| reg_wdata | input | 16 | Data for a full write |
| reg_wr_bit | input | 1 | Single-bit register write |
| reg_bit_idx | input | 4 | Bit position for a single-bit write |
| reg_bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | 16 | Register read-back |
| dm_slot | output | 2 | Current slot index sent to display memory |
| dm_bits | input | NUM_SEG | Segment bits for the current slot |
| com_lvl | output | 8 | Level index of commons 0 to 3, 2 bits each, common 0 in the low bits |
| seg_lvl | output | 2*NUM_SEG | Level index of each segment, 2 bits each, segment 0 in the low bits |

## Verification
The hardest case to reach is a mode and rate change that lands in the middle of a frame. To show that the old slot count and period survive until the frame boundary, the stimulus lets 4-slot drive run into its second slot. It then rewrites the register to 2-slot drive at the slower rate. Checks follow the last slot of the old frame, the boundary itself, and the new period and wrap. A second hard case is a strobe that is not present every cycle. One multiplex run and one static run drop every third strobe, so that the expected level is counted in strobes rather than in cycles.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    localparam int MAX_COM = 4;
    localparam int SLOT_W  = 2;
    localparam int MODE_W  = 3;
    localparam int RATE_W  = 2;
    localparam int REG_W   = 16;

    localparam int POS_DISP   = 15;
    localparam int POS_COMEN  = 14;
    localparam int POS_ASTOP  = 13;
    localparam int POS_SUPPLY = 12;
    localparam int POS_MODE   = 4;
    localparam int POS_RATE   = 0;

    localparam logic [REG_W-1:0] REG_MASK =
        (REG_W'(1) << POS_DISP) | (REG_W'(1) << POS_COMEN) |
        (REG_W'(1) << POS_ASTOP) | (REG_W'(1) << POS_SUPPLY) |
        (REG_W'((1 << MODE_W) - 1) << POS_MODE) |
        (REG_W'((1 << RATE_W) - 1) << POS_RATE);

    typedef enum logic [1:0] {LV0 = 2'd0, LV1 = 2'd1, LV2 = 2'd2, LV3 = 2'd3} lvl_e;

    typedef enum logic [1:0] {BIAS_THIRD, BIAS_HALF, BIAS_STATIC} bias_e;

    typedef struct packed {
        logic              disp_on;
        logic              com_en;
        logic              ana_stop;
        logic              supply_en;
        logic [MODE_W-1:0] mode;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    function automatic logic [2:0] mode_slots(input logic [MODE_W-1:0] m);
        case (m)
            3'd0:    return 3'd4;
            3'd1:    return 3'd3;
            3'd2:    return 3'd2;
            3'd3:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

    function automatic bias_e mode_bias(input logic [MODE_W-1:0] m);
        case (m)
            3'd0, 3'd1: return BIAS_THIRD;
            3'd2, 3'd3: return BIAS_HALF;
            default:    return BIAS_STATIC;
        endcase
    endfunction

endpackage

// File: rtl/lcd_ctrl_reg.sv
module lcd_ctrl_reg
    import lcd_mux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_full,
    input  logic [REG_W-1:0] wdata,
    input  logic             wr_bit,
    input  logic [3:0]       bit_idx,
    input  logic             bit_val,
    output logic [REG_W-1:0] rdata,
    output ctrl_t            ctrl
);

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_full) begin
            r_d.bits = wdata;
        end else if (wr_bit) begin
            r_d.bits[bit_idx] = bit_val;
        end
        r_d.bits = r_d.bits & REG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata          = r_q.bits;
    assign ctrl.disp_on   = r_q.bits[POS_DISP];
    assign ctrl.com_en    = r_q.bits[POS_COMEN];
    assign ctrl.ana_stop  = r_q.bits[POS_ASTOP];
    assign ctrl.supply_en = r_q.bits[POS_SUPPLY];
    assign ctrl.mode      = r_q.bits[POS_MODE +: MODE_W];
    assign ctrl.rate      = r_q.bits[POS_RATE +: RATE_W];

    // R2: a full write lands in the next cycle, masked to the stored bits
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |=> rdata == ($past(wdata) & REG_MASK));

    // R2: a lone bit write sets the chosen bit if it is stored
    p_bit_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit && !wr_full) |=>
            rdata[$past(bit_idx)] == ($past(bit_val) & REG_MASK[$past(bit_idx)]));

    // R1: register contents change only on a write
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_bit && !wr_full) |=> $stable(rdata));

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_mux_pkg::*;
#(
    parameter int BASE_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  ctrl_t             ctrl,
    output logic [SLOT_W-1:0] slot,
    output logic              pol,
    output logic [MODE_W-1:0] amode
);

    localparam int CNT_W = BASE_SHIFT + (1 << RATE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [MODE_W-1:0] amode;
        logic [RATE_W-1:0] arate;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0] last_cnt;
    logic [2:0]       nslots;
    logic             slot_end;
    logic             frame_end;

    always_comb begin
        last_cnt  = CNT_W'((1 << (BASE_SHIFT + int'(s_q.arate))) - 1);
        nslots    = mode_slots(s_q.amode);
        slot_end  = base_en && (s_q.cnt == last_cnt);
        frame_end = slot_end && ({1'b0, s_q.slot} == (nslots - 3'd1));

        s_d = s_q;
        if (!ctrl.com_en) begin
            s_d.cnt   = '0;
            s_d.slot  = '0;
            s_d.amode = ctrl.mode;
            s_d.arate = ctrl.rate;
        end else if (frame_end) begin
            s_d.cnt   = '0;
            s_d.slot  = '0;
            s_d.amode = ctrl.mode;
            s_d.arate = ctrl.rate;
        end else if (slot_end) begin
            s_d.cnt  = '0;
            s_d.slot = s_q.slot + SLOT_W'(1);
        end else if (base_en) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        pol   = s_q.cnt[BASE_SHIFT - 1 + int'(s_q.arate)];
        slot  = s_q.slot;
        amode = s_q.amode;
    end

    // R4: the slot index stays below the slot count of the active mode
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.slot} < mode_slots(s_q.amode));

    // R3: the prescaler never passes the end of the active period
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last_cnt);

    // R3: without a strobe a running prescaler holds its count
    p_gap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.com_en && !base_en) |=> $stable(s_q.cnt) && $stable(s_q.slot));

    // R10: commons disabled holds the timing at zero
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.com_en |=> (s_q.cnt == '0) && (s_q.slot == '0));

    // R11: the active mode only changes when a new frame starts
    p_cfg_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.amode) |-> (s_q.slot == '0) && (s_q.cnt == '0));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_mux_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic [SLOT_W-1:0]      slot,
    input  logic                   pol,
    input  logic [MODE_W-1:0]      amode,
    input  logic                   disp_on,
    input  logic                   com_en,
    input  logic [NUM_SEG-1:0]     dm_bits,
    output logic [2*MAX_COM-1:0]   com_lvl,
    output logic [2*NUM_SEG-1:0]   seg_lvl
);

    bias_e bias;
    lvl_e  com_sel;
    lvl_e  com_nsel;
    lvl_e  com_static;
    lvl_e  seg_on;
    lvl_e  seg_off;

    always_comb begin
        bias       = mode_bias(amode);
        com_sel    = pol ? LV0 : LV3;
        com_static = pol ? LV3 : LV0;
        com_nsel   = (bias == BIAS_HALF) ? LV1 : (pol ? LV2 : LV1);
        if (bias == BIAS_STATIC) begin
            seg_on  = pol ? LV0 : LV3;
            seg_off = com_static;
        end else if (bias == BIAS_HALF) begin
            seg_on  = pol ? LV3 : LV0;
            seg_off = pol ? LV0 : LV3;
        end else begin
            seg_on  = pol ? LV3 : LV0;
            seg_off = pol ? LV1 : LV2;
        end
    end

    for (genvar gi = 0; gi < MAX_COM; gi++) begin : g_com
        lvl_e lvl;
        always_comb begin
            if (!com_en) begin
                lvl = LV0;
            end else if (bias == BIAS_STATIC) begin
                lvl = (gi == 0) ? com_static : LV0;
            end else if (slot == SLOT_W'(gi)) begin
                lvl = com_sel;
            end else begin
                lvl = com_nsel;
            end
        end
        assign com_lvl[2*gi +: 2] = lvl;
    end

    for (genvar gj = 0; gj < NUM_SEG; gj++) begin : g_seg
        lvl_e lvl;
        always_comb begin
            if (!com_en) begin
                lvl = LV0;
            end else if (disp_on && dm_bits[gj]) begin
                lvl = seg_on;
            end else begin
                lvl = seg_off;
            end
        end
        assign seg_lvl[2*gj +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_mux_timing.sv
module lcd_mux_timing
    import lcd_mux_pkg::*;
#(
    parameter int NUM_SEG    = 8,
    parameter int BASE_SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_en,
    input  logic                 reg_wr_full,
    input  logic [15:0]          reg_wdata,
    input  logic                 reg_wr_bit,
    input  logic [3:0]           reg_bit_idx,
    input  logic                 reg_bit_val,
    output logic [15:0]          reg_rdata,
    output logic [1:0]           dm_slot,
    input  logic [NUM_SEG-1:0]   dm_bits,
    output logic [7:0]           com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);

    ctrl_t             ctrl;
    logic [SLOT_W-1:0] slot;
    logic              pol;
    logic [MODE_W-1:0] amode;

    lcd_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (reg_wr_full),
        .wdata   (reg_wdata),
        .wr_bit  (reg_wr_bit),
        .bit_idx (reg_bit_idx),
        .bit_val (reg_bit_val),
        .rdata   (reg_rdata),
        .ctrl    (ctrl)
    );

    lcd_frame_seq #(.BASE_SHIFT(BASE_SHIFT)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_en (base_en),
        .ctrl    (ctrl),
        .slot    (slot),
        .pol     (pol),
        .amode   (amode)
    );

    lcd_level_map #(.NUM_SEG(NUM_SEG)) u_map (
        .slot    (slot),
        .pol     (pol),
        .amode   (amode),
        .disp_on (ctrl.disp_on),
        .com_en  (ctrl.com_en),
        .dm_bits (dm_bits),
        .com_lvl (com_lvl),
        .seg_lvl (seg_lvl)
    );

    assign dm_slot = slot;

    logic [MAX_COM-1:0] sel_hits;
    logic [NUM_SEG-1:0] seg_mid;
    always_comb begin
        for (int i = 0; i < MAX_COM; i++) begin
            sel_hits[i] = com_lvl[2*i +: 2] == (pol ? 2'd0 : 2'd3);
        end
        for (int j = 0; j < NUM_SEG; j++) begin
            seg_mid[j] = (seg_lvl[2*j +: 2] == 2'd1) || (seg_lvl[2*j +: 2] == 2'd2);
        end
    end

    // R5 R6: exactly one common carries the selected level while multiplexing
    p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.com_en && !amode[2]) |-> $countones(sel_hits) == 1);

    // R9: with display off under 1/3 bias every segment sits on a middle rail
    p_disp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.com_en && !ctrl.disp_on && (mode_bias(amode) == BIAS_THIRD)) |->
            (&seg_mid));

    // R10: commons disabled forces every pin to V0
    p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.com_en |-> (com_lvl == '0) && (seg_lvl == '0));

endmodule

// File: tb/lcd_mux_timing_bench.sv
`timescale 1ns/1ps
module lcd_mux_timing_bench;

    localparam int NS = 8;
    localparam int VW = 2 * (4 + NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_en = 1'b0;
    logic          reg_wr_full = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic          reg_wr_bit = 1'b0;
    logic [3:0]    reg_bit_idx = '0;
    logic          reg_bit_val = 1'b0;
    logic [15:0]   reg_rdata;
    logic [1:0]    dm_slot;
    logic [NS-1:0] dm_bits;
    logic [7:0]    com_lvl;
    logic [2*NS-1:0] seg_lvl;
    logic [NS-1:0] mem [4];

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign dm_bits = mem[dm_slot];

    lcd_mux_timing #(.NUM_SEG(NS)) u_lcd_mux_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_en     (base_en),
        .reg_wr_full (reg_wr_full),
        .reg_wdata   (reg_wdata),
        .reg_wr_bit  (reg_wr_bit),
        .reg_bit_idx (reg_bit_idx),
        .reg_bit_val (reg_bit_val),
        .reg_rdata   (reg_rdata),
        .dm_slot     (dm_slot),
        .dm_bits     (dm_bits),
        .com_lvl     (com_lvl),
        .seg_lvl     (seg_lvl)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int slots_of(input logic [2:0] m);
        case (m)
            3'd0: return 4;
            3'd1: return 3;
            3'd2: return 2;
            3'd3: return 3;
            default: return 1;
        endcase
    endfunction

    // expected {com, seg} levels taken from the requirement text
    function automatic logic [VW-1:0] model(input int slot, input bit pol,
                                            input logic [2:0] m, input bit disp,
                                            input logic [NS-1:0] bits);
        logic [VW-1:0] r;
        bit stat;
        bit half;
        r = '0;
        stat = m[2];
        half = (m == 3'd2) || (m == 3'd3);
        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            if (stat) c = (i == 0) ? (pol ? 2'd3 : 2'd0) : 2'd0;
            else if (i == slot) c = pol ? 2'd0 : 2'd3;
            else c = half ? 2'd1 : (pol ? 2'd2 : 2'd1);
            r[2*NS + 2*i +: 2] = c;
        end
        for (int j = 0; j < NS; j++) begin
            logic [1:0] s;
            bit on;
            on = disp && bits[j];
            if (stat) s = on ? (pol ? 2'd0 : 2'd3) : (pol ? 2'd3 : 2'd0);
            else if (on) s = pol ? 2'd3 : 2'd0;
            else if (half) s = pol ? 2'd0 : 2'd3;
            else s = pol ? 2'd1 : 2'd2;
            r[2*j +: 2] = s;
        end
        return r;
    endfunction

    task automatic check_at(input string req, input int k, input logic [2:0] m,
                            input logic [1:0] rate, input bit disp);
        int p;
        int slot;
        bit pol;
        p = 1 << (6 + rate);
        slot = (k / p) % slots_of(m);
        pol = (k % p) >= (p / 2);
        chk({req, " slot"}, 64'(dm_slot), 64'(slot));
        chk({req, " levels"}, 64'({com_lvl, seg_lvl}), 64'(model(slot, pol, m, disp, mem[slot])));
    endtask

    task automatic write_full(input logic [15:0] d);
        reg_wdata = d;
        reg_wr_full = 1'b1;
        @(negedge clk);
        reg_wr_full = 1'b0;
    endtask

    task automatic write_bit(input int idx, input bit v);
        reg_bit_idx = 4'(idx);
        reg_bit_val = v;
        reg_wr_bit = 1'b1;
        @(negedge clk);
        reg_wr_bit = 1'b0;
    endtask

    function automatic logic [15:0] cfg(input bit disp, input bit extra,
                                        input logic [2:0] m, input logic [1:0] rate);
        return {disp, 1'b0, extra, extra, 5'b0, m, 2'b0, rate};
    endfunction

    function automatic bit sample_pt(input int k, input int p);
        return ((k % (p / 2)) == 0) || ((k % (p / 2)) == (p / 2 - 1));
    endfunction

    task automatic t_reset();
        chk("R1 reset value", 64'(reg_rdata), 64'h0);
        chk("R10 reset outputs", 64'({com_lvl, seg_lvl}), 64'h0);
        chk("R10 reset slot", 64'(dm_slot), 64'h0);
    endtask

    task automatic t_regs();
        write_full(16'hFFFF);
        chk("R1 R2 full write mask", 64'(reg_rdata), 64'hF073);
        write_bit(13, 1'b0);
        chk("R2 bit write", 64'(reg_rdata), 64'hD073);
        write_bit(9, 1'b1);
        chk("R1 unstored bit", 64'(reg_rdata), 64'hD073);
        reg_wdata = 16'h0001;
        reg_wr_full = 1'b1;
        reg_bit_idx = 4'd15;
        reg_bit_val = 1'b1;
        reg_wr_bit = 1'b1;
        @(negedge clk);
        reg_wr_full = 1'b0;
        reg_wr_bit = 1'b0;
        chk("R2 full beats bit", 64'(reg_rdata), 64'h0001);
        write_full(16'h0000);
        chk("R2 clear", 64'(reg_rdata), 64'h0);
    endtask

    // one run of two full frames in a mode, checked at half-slot edges
    task automatic run_mode(input string req, input logic [2:0] m, input logic [1:0] rate,
                            input bit disp, input bit extra, input bit gappy);
        int p;
        int k;
        int cyc;
        bit be;
        p = 1 << (6 + rate);
        k = 0;
        cyc = 0;
        base_en = 1'b1;
        write_full(cfg(disp, extra, m, rate));
        write_bit(14, 1'b1);
        while (k < 2 * slots_of(m) * p) begin
            if (sample_pt(k, p)) check_at(req, k, m, rate, disp);
            be = gappy ? ((cyc % 3) != 2) : 1'b1;
            base_en = be;
            @(negedge clk);
            if (be) k++;
            cyc++;
        end
        base_en = 1'b1;
        write_full(16'h0000);
    endtask

    task automatic t_switch();
        int k;
        base_en = 1'b1;
        write_full(cfg(1'b1, 1'b0, 3'd0, 2'd0));
        write_bit(14, 1'b1);
        k = 0;
        while (k < 256 + 512) begin
            if (k < 256) begin
                if (sample_pt(k, 64) || k == 200) check_at("R11 old frame", k, 3'd0, 2'd0, 1'b1);
            end else begin
                if (sample_pt(k - 256, 128)) check_at("R11 new frame", k - 256, 3'd2, 2'd1, 1'b1);
            end
            if (k == 70) begin
                reg_wdata = {1'b1, 1'b1, 2'b0, 5'b0, 3'd2, 2'b0, 2'd1};
                reg_wr_full = 1'b1;
            end
            @(negedge clk);
            reg_wr_full = 1'b0;
            k++;
        end
        write_full(16'h0000);
    endtask

    task automatic t_comoff();
        base_en = 1'b1;
        write_full(cfg(1'b1, 1'b0, 3'd0, 2'd0));
        write_bit(14, 1'b1);
        repeat (100) @(negedge clk);
        write_bit(14, 1'b0);
        chk("R10 outputs off", 64'({com_lvl, seg_lvl}), 64'h0);
        repeat (20) @(negedge clk);
        chk("R10 held outputs", 64'({com_lvl, seg_lvl}), 64'h0);
        chk("R10 held slot", 64'(dm_slot), 64'h0);
        write_bit(14, 1'b1);
        for (int k = 0; k <= 64; k++) begin
            if (k == 0 || k == 31 || k == 32 || k == 64)
                check_at("R10 restart", k, 3'd0, 2'd0, 1'b1);
            @(negedge clk);
        end
        write_full(16'h0000);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        mem[0] = 8'hA5;
        mem[1] = 8'h3C;
        mem[2] = 8'h0F;
        mem[3] = 8'hF1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        run_mode("R3 R4 R5 R7 R12", 3'd0, 2'd0, 1'b1, 1'b0, 1'b0);
        run_mode("R4 R5 R7", 3'd1, 2'd0, 1'b1, 1'b0, 1'b0);
        run_mode("R4 R6 R7", 3'd2, 2'd1, 1'b1, 1'b0, 1'b0);
        run_mode("R3 R4 R6", 3'd3, 2'd0, 1'b1, 1'b0, 1'b1);
        run_mode("R3 R8", 3'd4, 2'd2, 1'b1, 1'b0, 1'b0);
        run_mode("R8", 3'd7, 2'd0, 1'b1, 1'b0, 1'b1);
        run_mode("R9", 3'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        run_mode("R13", 3'd1, 2'd3, 1'b1, 1'b1, 1'b0);
        t_switch();
        t_comoff();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule